// File: doc/BRIEF.md
# Phase-Bit Descriptor Ring Consumer

This block walks a circular ring of fixed-size descriptors held in local memory. It decides whether each slot holds fresh work by comparing the slot's phase bit with a phase value that it tracks itself. The producer inverts the phase bit it writes each time its write pointer passes the end of the ring. Because of this, the two sides never exchange a head pointer, and a slot the producer has not yet rewritten reads as empty. On an empty slot the consumer stays on that slot and keeps polling it.

For each valid slot, the block reads only the words it needs through a single-word memory read port with one cycle of latency. From them it computes the byte address of the packet data and the byte count of the segment, and it notes whether more segments of the same packet follow. It then presents one segment record on a valid/ready stream, marked with start-of-packet and end-of-packet. It moves to the next slot only after the downstream side has accepted the record.

Top module: `dring_consumer`

## Requirements
- R1: While reset is held, and on the first cycle after reset, `seg_valid` is 0 and the read port addresses word 7 of slot 0 (word address 7).
- R2: Slot n occupies the eight words at word addresses 8n to 8n+7. Every fetch of a slot begins with a read of its word 7.
- R3: Bit 8 of word 7 is the phase bit. A slot whose phase bit differs from the expected phase produces no record, and the block keeps re-reading word 7 of that same slot until the bit matches.
- R4: The expected phase is 1 after reset and inverts each time the read index steps from the last slot back to slot 0. On the second pass, slots still carrying phase 1 are therefore empty, and slots carrying phase 0 are valid.
- R5: `seg_addr` equals the 40-bit base formed as {word 1 bits 7:0, word 0 bits 31:0}, plus the 12-bit offset in word 6 bits 11:0. The sum is taken modulo 2^40.
- R6: `seg_len` equals word 5 bits 17:0. The other bits of word 5 have no effect.
- R7: `seg_eop` is the inverse of word 1 bit 30. A value of 1 in that bit means more segments of the same packet follow.
- R8: `seg_sop` is 1 on the first record after reset and on the first record after any accepted record with `seg_eop` = 1. It is 0 otherwise.
- R9: While `seg_valid` is 1 and `seg_ready` is 0, the record and `seg_valid` stay unchanged.
- R10: The read index advances only on a completed handshake. While a record waits, no memory read is issued. `seg_valid` drops on the edge that completes the handshake.
- R11: Reads are never issued on two consecutive cycles. When the slot is already valid at the start of its fetch, `seg_valid` rises on the tenth rising clock edge after the fetch begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | IDX_W+3 | Word address of the read |
| rd_data | input | 32 | Read data, valid one cycle after `rd_en` |
| seg_valid | output | 1 | Segment record available |
| seg_ready | input | 1 | Downstream accepts the record |
| seg_addr | output | 40 | Byte address of the segment data |
| seg_len | output | 18 | Segment byte count |
| seg_sop | output | 1 | First segment of a packet |
| seg_eop | output | 1 | Last segment of a packet |

## Verification
A slot takes five reads, each followed one cycle later by its capture, so a record is due on the tenth rising edge after its fetch starts. The bench checks this exactly once after reset, by counting edges from the release of reset and sampling on the falling edges either side of the tenth. For the later slots, the bench waits for `seg_valid` on falling edges under a bound and then checks the fields. A drop in `seg_valid` is due one edge after the handshake, and the bench samples it on the next falling edge. Empty-slot stalls are observed over a fixed window of falling edges, during which the bench requires that no record appears and that every read addresses word 7 of the stalled slot.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int DW        = 32;
  localparam int BUF_AW    = 40;
  localparam int LEN_W     = 18;
  localparam int OFF_W     = 12;
  localparam int WSEL_W    = 3;
  localparam int STEP_LAST = 4;

  localparam int PHASE_BIT = 8;
  localparam int MORE_BIT  = 30;

  localparam logic [WSEL_W-1:0] WD_BASE_LO = 3'd0;
  localparam logic [WSEL_W-1:0] WD_CTRL    = 3'd1;
  localparam logic [WSEL_W-1:0] WD_LEN     = 3'd5;
  localparam logic [WSEL_W-1:0] WD_OFF     = 3'd6;
  localparam logic [WSEL_W-1:0] WD_PHASE   = 3'd7;

  typedef enum logic [1:0] {FS_REQ, FS_CAP, FS_HOLD} fetch_state_t;

  typedef struct packed {
    logic [BUF_AW-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              sop;
    logic              eop;
  } seg_rec_t;

  // Word read at each fetch step; the phase word comes first.
  function automatic logic [WSEL_W-1:0] step_word(input logic [2:0] step);
    case (step)
      3'd0:    step_word = WD_PHASE;
      3'd1:    step_word = WD_BASE_LO;
      3'd2:    step_word = WD_CTRL;
      3'd3:    step_word = WD_LEN;
      default: step_word = WD_OFF;
    endcase
  endfunction
endpackage

// File: rtl/dring_cursor.sv
module dring_cursor #(
  parameter int RING_ENTRIES = 8,
  parameter int IDX_W        = (RING_ENTRIES > 1) ? $clog2(RING_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic             phase
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_ENTRIES - 1);
  localparam bit POW2 = (RING_ENTRIES == (1 << IDX_W));

  logic             at_last;
  logic [IDX_W-1:0] idx_nxt;

  assign at_last = (idx == LAST_IDX);

  generate
    if (POW2) begin : g_pow2
      assign idx_nxt = idx + 1'b1;
    end else begin : g_cmp
      assign idx_nxt = at_last ? '0 : idx + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      phase <= 1'b1;
    end else if (advance) begin
      idx <= idx_nxt;
      if (at_last) phase <= ~phase;
    end
  end
endmodule

// File: rtl/dring_pkt_track.sv
module dring_pkt_track (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic acc_eop,
  output logic sop_next
);
  always_ff @(posedge clk) begin
    if (rst)         sop_next <= 1'b1;
    else if (accept) sop_next <= acc_eop;
  end
endmodule

// File: rtl/dring_fetch.sv
module dring_fetch
  import dring_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IDX_W-1:0]        idx,
  input  logic                    phase,
  input  logic                    sop_next,
  output logic                    rd_en,
  output logic [IDX_W+WSEL_W-1:0] rd_addr,
  input  logic [DW-1:0]           rd_data,
  output logic                    seg_valid,
  input  logic                    seg_ready,
  output seg_rec_t                rec,
  output logic                    advance
);
  fetch_state_t           st;
  logic [2:0]             step;
  logic [DW-1:0]          base_lo;
  logic [BUF_AW-DW-1:0]   base_hi;
  logic                   more_q;
  logic [LEN_W-1:0]       len_q;

  assign rd_en   = (st == FS_REQ);
  assign rd_addr = {idx, step_word(step)};
  assign advance = (st == FS_HOLD) && seg_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= FS_REQ;
      step      <= '0;
      seg_valid <= 1'b0;
      rec       <= '0;
      base_lo   <= '0;
      base_hi   <= '0;
      more_q    <= 1'b0;
      len_q     <= '0;
    end else begin
      case (st)
        FS_REQ: st <= FS_CAP;
        FS_CAP: begin
          st <= FS_REQ;
          case (step)
            3'd0: if (rd_data[PHASE_BIT] == phase) step <= 3'd1;
            3'd1: begin
              base_lo <= rd_data;
              step    <= 3'd2;
            end
            3'd2: begin
              base_hi <= rd_data[BUF_AW-DW-1:0];
              more_q  <= rd_data[MORE_BIT];
              step    <= 3'd3;
            end
            3'd3: begin
              len_q <= rd_data[LEN_W-1:0];
              step  <= 3'(STEP_LAST);
            end
            default: begin
              rec.addr  <= {base_hi, base_lo} + BUF_AW'(rd_data[OFF_W-1:0]);
              rec.len   <= len_q;
              rec.eop   <= ~more_q;
              rec.sop   <= sop_next;
              seg_valid <= 1'b1;
              step      <= '0;
              st        <= FS_HOLD;
            end
          endcase
        end
        default: begin
          if (seg_ready) begin
            seg_valid <= 1'b0;
            st        <= FS_REQ;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dring_consumer.sv
module dring_consumer
  import dring_pkg::*;
#(
  parameter int RING_ENTRIES = 8,
  parameter int IDX_W        = (RING_ENTRIES > 1) ? $clog2(RING_ENTRIES) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic                    rd_en,
  output logic [IDX_W+WSEL_W-1:0] rd_addr,
  input  logic [DW-1:0]           rd_data,
  output logic                    seg_valid,
  input  logic                    seg_ready,
  output logic [BUF_AW-1:0]       seg_addr,
  output logic [LEN_W-1:0]        seg_len,
  output logic                    seg_sop,
  output logic                    seg_eop
);
  logic [IDX_W-1:0] idx;
  logic             phase;
  logic             sop_next;
  logic             advance;
  seg_rec_t         rec;

  dring_cursor #(.RING_ENTRIES(RING_ENTRIES), .IDX_W(IDX_W)) u_cursor (
    .clk(clk), .rst(rst), .advance(advance), .idx(idx), .phase(phase)
  );

  dring_pkt_track u_pkt (
    .clk(clk), .rst(rst), .accept(advance), .acc_eop(rec.eop), .sop_next(sop_next)
  );

  dring_fetch #(.IDX_W(IDX_W)) u_fetch (
    .clk(clk), .rst(rst), .idx(idx), .phase(phase), .sop_next(sop_next),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .rec(rec), .advance(advance)
  );

  assign seg_addr = rec.addr;
  assign seg_len  = rec.len;
  assign seg_sop  = rec.sop;
  assign seg_eop  = rec.eop;
endmodule

// File: rtl/dring_consumer_chk.sv
module dring_consumer_chk #(
  parameter int RING_ENTRIES = 8,
  parameter int IDX_W        = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en,
  input logic [IDX_W+2:0] rd_addr,
  input logic             seg_valid,
  input logic             seg_ready,
  input logic [39:0]      seg_addr,
  input logic [17:0]      seg_len,
  input logic             seg_sop,
  input logic             seg_eop
);
  logic             m_sop;
  logic [IDX_W-1:0] m_idx;
  logic             hs;

  assign hs = seg_valid && seg_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_sop <= 1'b1;
      m_idx <= '0;
    end else if (hs) begin
      m_sop <= seg_eop;
      m_idx <= (m_idx == IDX_W'(RING_ENTRIES - 1)) ? '0 : m_idx + 1'b1;
    end
  end

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len)
                               && $stable(seg_sop) && $stable(seg_eop));

  p_read_gap_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

  p_no_read_hold_r10: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> !rd_en);

  p_drop_after_hs_r10: assert property (@(posedge clk) disable iff (rst)
    hs |=> !seg_valid && rd_en && rd_addr[2:0] == 3'd7);

  p_slot_order_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> rd_addr[IDX_W+2:3] == m_idx);

  p_sop_rule_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(seg_valid) |-> seg_sop == m_sop);
endmodule

bind dring_consumer dring_consumer_chk #(.RING_ENTRIES(RING_ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
  .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
  .seg_len(seg_len), .seg_sop(seg_sop), .seg_eop(seg_eop)
);

// File: tb/sim_dring_consumer.sv
module sim_dring_consumer;
  localparam int CLK_PERIOD = 10;
  localparam int RING = 4;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data = '0;
  logic          seg_valid;
  logic          seg_ready = 1'b0;
  logic [39:0]   seg_addr;
  logic [17:0]   seg_len;
  logic          seg_sop;
  logic          seg_eop;

  logic [31:0] mem [RING*8];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  dring_consumer #(.RING_ENTRIES(RING)) u0 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_sop(seg_sop), .seg_eop(seg_eop)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put_slot(input int s, input bit ph, input logic [39:0] base,
                          input logic [11:0] off, input logic [17:0] len, input bit more);
    mem[s*8+0] = base[31:0];
    mem[s*8+1] = 32'h1234_5600 | (32'(more) << 30) | 32'(base[39:32]);
    mem[s*8+5] = 32'hFC00_0000 | 32'(len);
    mem[s*8+6] = 32'hBEEF_0000 | 32'(off);
    mem[s*8+7] = 32'hA5A5_003C | (32'(ph) << 8);
  endtask

  task automatic check_rec(input string tag, input logic [39:0] ea, input logic [17:0] el,
                           input bit es, input bit ee);
    chk(seg_addr == ea, {tag, " R5 addr"}, 64'(seg_addr), 64'(ea));
    chk(seg_len == el,  {tag, " R6 len"},  64'(seg_len),  64'(el));
    chk(seg_eop == ee,  {tag, " R7 eop"},  64'(seg_eop),  64'(ee));
    chk(seg_sop == es,  {tag, " R8 sop"},  64'(seg_sop),  64'(es));
  endtask

  task automatic accept_rec();
    seg_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    seg_ready = 1'b0;
    chk(seg_valid == 1'b0, "R10 valid drops after handshake", 64'(seg_valid), 64'd0);
  endtask

  task automatic take(input string tag, input logic [39:0] ea, input logic [17:0] el,
                      input bit es, input bit ee);
    int n = 0;
    while (!seg_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(seg_valid == 1'b1, {tag, " R3 record appears"}, 64'(seg_valid), 64'd1);
    check_rec(tag, ea, el, es, ee);
    accept_rec();
  endtask

  task automatic t_empty(input string tag, input logic [AW-1:0] exp_addr);
    int bad_v = 0;
    int bad_a = 0;
    int reads = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (seg_valid) bad_v++;
      if (rd_en) begin
        reads++;
        if (rd_addr != exp_addr) bad_a++;
      end
    end
    chk(bad_v == 0, {tag, " no record from empty slot"}, 64'(bad_v), 64'd0);
    chk(bad_a == 0 && reads > 0, {tag, " re-poll phase word"}, 64'(bad_a), 64'd0);
  endtask

  task automatic t_reset_latency();
    for (int i = 0; i < RING*8; i++) mem[i] = '0;
    put_slot(0, 1'b1, 40'h12_3456_7000, 12'h010, 18'h00200, 1'b1);
    repeat (3) @(negedge clk);
    chk(seg_valid == 1'b0, "R1 valid low in reset", 64'(seg_valid), 64'd0);
    chk(rd_addr == 5'd7, "R1 R2 first read at word 7", 64'(rd_addr), 64'd7);
    rst = 1'b0;
    #1;
    chk(rd_en == 1'b1 && rd_addr == 5'd7, "R1 read after reset", 64'(rd_addr), 64'd7);
    repeat (9) @(posedge clk);
    @(negedge clk);
    chk(seg_valid == 1'b0, "R11 not before edge 10", 64'(seg_valid), 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk(seg_valid == 1'b1, "R11 valid at edge 10", 64'(seg_valid), 64'd1);
    check_rec("slot0", 40'h12_3456_7010, 18'h00200, 1'b1, 1'b0);
  endtask

  task automatic t_backpressure();
    int moved = 0;
    int reads = 0;
    logic [39:0] a0 = seg_addr;
    put_slot(1, 1'b1, 40'h00_ABCD_0000, 12'h800, 18'h10000, 1'b0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!seg_valid || seg_addr != a0 || seg_len != 18'h00200 || !seg_sop || seg_eop) moved++;
      if (rd_en) reads++;
    end
    chk(moved == 0, "R9 record held under stall", 64'(moved), 64'd0);
    chk(reads == 0, "R10 no read while waiting", 64'(reads), 64'd0);
    accept_rec();
  endtask

  task automatic t_chain();
    take("slot1", 40'h00_ABCD_0800, 18'h10000, 1'b0, 1'b1);
  endtask

  task automatic t_stall_then_fill();
    t_empty("R3 slot2", 5'd23);
    put_slot(2, 1'b1, 40'h80_0000_0FFF, 12'h001, 18'h00040, 1'b0);
    take("slot2", 40'h80_0000_1000, 18'h00040, 1'b1, 1'b1);
    put_slot(3, 1'b1, 40'h01_0000_0000, 12'h000, 18'h00001, 1'b1);
    take("slot3", 40'h01_0000_0000, 18'h00001, 1'b1, 1'b0);
  endtask

  task automatic t_wrap_phase();
    t_empty("R4 stale slot0", 5'd7);
    put_slot(0, 1'b0, 40'hFF_FFFF_FF00, 12'h1F0, 18'h3FFFF, 1'b0);
    take("R4 slot0 lap2", 40'h00_0000_00F0, 18'h3FFFF, 1'b0, 1'b1);
    t_empty("R4 stale slot1", 5'd15);
    put_slot(1, 1'b0, 40'h00_0000_1000, 12'hFFF, 18'h00000, 1'b1);
    take("R4 slot1 lap2", 40'h00_0000_1FFF, 18'h00000, 1'b1, 1'b0);
  endtask

  initial begin
    t_reset_latency();
    t_backpressure();
    t_chain();
    t_stall_then_fill();
    t_wrap_phase();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule